// File: doc/BRIEF.md
# Quad-Channel UART FIFO Request Pin Generator

This block drives the two active-low request pins that a DMA controller watches on a four-channel UART with 16-byte FIFOs. One pin reports that received data is waiting. The other reports that the transmit FIFO can take more bytes. Each channel supplies the following inputs:

- its receive and transmit FIFO fill levels;
- a 2-bit receive trigger select;
- a mode bit;
- strobes for "character received", "FIFO read" and "one character time elapsed".

Each channel has two request modes:

- **Mode 0** signals simple occupancy. The receive request is asserted while the receive FIFO is non-empty. The transmit request is asserted only while the transmit FIFO is completely empty.
- **Mode 1** batches transfers. The receive request is asserted once the FIFO reaches the trigger level, or once four character times pass with data waiting and no activity. After that it stays asserted until the FIFO drains to zero. The transmit request is asserted whenever the FIFO has room.

Each channel's character timeout is counted inside the block. The per-channel active-low requests are ANDed onto the shared pins, so a pin goes low as soon as any channel requests. Both pins are registered. All inputs are plain level or strobe signals. There is no handshake or back-pressure at the block's edge: the strobes are sampled on every clock edge and never stalled.

Top module: `uart_dma_ready`

## Requirements
- R1: While reset is held and right after it, `rxrdy_n` is 1 and `txrdy_n` is 0, matching empty FIFOs in mode 0.
- R2: A channel in mode 0 (mode bit 0) requests receive service exactly while its receive level is non-zero.
- R3: A channel in mode 1 (mode bit 1) requests receive service when its receive level is at or above the trigger. The trigger select encodes 00 as 1 byte, 01 as 4, 10 as 8 and 11 as 14.
- R4: In mode 1, a receive request stays asserted while the level falls below the trigger. It is released only when the level reaches zero.
- R5: In mode 1, four `char_tick` pulses with a non-empty receive FIFO and no push or pop assert the receive request. Assertion occurs in the cycle after the fourth pulse is counted, regardless of trigger.
- R6: A push or pop strobe restarts the timeout count. A tick in the same cycle as a push or pop is not counted.
- R7: The timeout count stays at zero while the receive FIFO is empty.
- R8: A channel in mode 0 requests transmit service exactly while its transmit level is zero.
- R9: A channel in mode 1 requests transmit service exactly while its transmit level is below 16.
- R10: Each shared pin is low when at least one channel requests and high when none does.
- R11: Both pins are registered: they reflect the inputs of the previous clock cycle and never change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | 20 | Receive FIFO level, 5 bits per channel, channel 0 in the low bits |
| tx_level | input | 20 | Transmit FIFO level, 5 bits per channel |
| trig_sel | input | 8 | Receive trigger select, 2 bits per channel |
| mode | input | 4 | Request mode per channel, 0 or 1 |
| rx_push | input | 4 | Character written into the receive FIFO, per channel |
| rx_pop | input | 4 | Receive FIFO read, per channel |
| char_tick | input | 4 | One pulse per character time, per channel |
| rxrdy_n | output | 1 | Shared active-low receive request |
| txrdy_n | output | 1 | Shared active-low transmit request |

## Verification
The timeout counter can see a character-time tick and a push or pop strobe in the same cycle. The restart must win, so the tick is lost. The bench drives ticks together with pushes, both in a directed case and in random cycles where the strobes overlap freely. A bench model counts the tick only when no strobe is present, and the pin's release or assertion timing is compared with that model every cycle. A second collision occurs when the receive level drops to zero in the same cycle that a timeout expires. The model requires the pin to release in that case.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

  localparam int TRIG_SEL_W = 2;

  // Receive trigger select decoding
  function automatic int unsigned trig_bytes(input logic [TRIG_SEL_W-1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/char_timeout.sv
module char_timeout #(
  parameter int TO_CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nonempty,
  input  logic restart,
  input  logic tick,
  output logic expired
);
  localparam int CNT_W = $clog2(TO_CHARS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TO_CHARS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (restart || !nonempty)       cnt_q <= '0;
    else if (tick && cnt_q != LIMIT)     cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == LIMIT);

  a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);
  a_r7_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !nonempty |=> cnt_q == '0);
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
endmodule

// File: rtl/rx_chan_ready.sv
module rx_chan_ready
  import uart_dma_pkg::*;
#(
  parameter int LVL_W    = 5,
  parameter int TO_CHARS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LVL_W-1:0]      level,
  input  logic [TRIG_SEL_W-1:0] trig_sel,
  input  logic                  mode,
  input  logic                  push,
  input  logic                  pop,
  input  logic                  tick,
  output logic                  act
);
  logic nonempty, expired, at_trig, batch_act, hold_q;
  logic [LVL_W-1:0] trig_lvl;

  assign nonempty = (level != '0);
  assign trig_lvl = LVL_W'(trig_bytes(trig_sel));
  assign at_trig  = (level >= trig_lvl);

  char_timeout #(.TO_CHARS(TO_CHARS)) i_timeout (
    .clk     (clk),
    .rst_n   (rst_n),
    .nonempty(nonempty),
    .restart (push | pop),
    .tick    (tick),
    .expired (expired)
  );

  // Batching mode: latch the request until the FIFO drains
  assign batch_act = nonempty && (hold_q || at_trig || expired);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= batch_act;
  end

  assign act = mode ? batch_act : nonempty;

  a_r4_release_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !nonempty |=> !hold_q);
  a_r4_sticky_until_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && $past(act) && nonempty && $past(mode)) |-> act);
  a_r3_trigger_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && level >= trig_lvl && nonempty) |-> act);
endmodule

// File: rtl/tx_chan_ready.sv
module tx_chan_ready #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic             mode,
  output logic             act
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  assign act = mode ? (level < FULL) : (level == '0);

  a_r9_full_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && level >= FULL) |-> !act);
  a_r8_busy_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && level != '0) |-> !act);
endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready
  import uart_dma_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4,
  parameter int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH*LVL_W-1:0]      rx_level,
  input  logic [NCH*LVL_W-1:0]      tx_level,
  input  logic [NCH*TRIG_SEL_W-1:0] trig_sel,
  input  logic [NCH-1:0]            mode,
  input  logic [NCH-1:0]            rx_push,
  input  logic [NCH-1:0]            rx_pop,
  input  logic [NCH-1:0]            char_tick,
  output logic                      rxrdy_n,
  output logic                      txrdy_n
);
  logic [NCH-1:0] rx_act, tx_act;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    rx_chan_ready #(.LVL_W(LVL_W), .TO_CHARS(TO_CHARS)) i_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .level   (rx_level[c*LVL_W +: LVL_W]),
      .trig_sel(trig_sel[c*TRIG_SEL_W +: TRIG_SEL_W]),
      .mode    (mode[c]),
      .push    (rx_push[c]),
      .pop     (rx_pop[c]),
      .tick    (char_tick[c]),
      .act     (rx_act[c])
    );
    tx_chan_ready #(.DEPTH(DEPTH), .LVL_W(LVL_W)) i_tx (
      .clk  (clk),
      .rst_n(rst_n),
      .level(tx_level[c*LVL_W +: LVL_W]),
      .mode (mode[c]),
      .act  (tx_act[c])
    );
  end

  // Active-low per-channel requests combined by AND
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxrdy_n <= 1'b1;
      txrdy_n <= 1'b0;
    end else begin
      rxrdy_n <= &(~rx_act);
      txrdy_n <= &(~tx_act);
    end
  end

  a_r10_rx_any_low: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_act) |=> !rxrdy_n);
  a_r10_rx_none_high: assert property (@(posedge clk) disable iff (!rst_n)
    !(|rx_act) |=> rxrdy_n);
  a_r10_tx_any_low: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_act) |=> !txrdy_n);
  a_r10_tx_none_high: assert property (@(posedge clk) disable iff (!rst_n)
    !(|tx_act) |=> txrdy_n);
endmodule

// File: tb/test_uart_dma_ready.sv
module test_uart_dma_ready;
  localparam int NCH = 4;
  localparam int LW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH*LW-1:0] rx_level = '0, tx_level = '0;
  logic [NCH*2-1:0]  trig_sel = '0;
  logic [NCH-1:0]    mode = '0, rx_push = '0, rx_pop = '0, char_tick = '0;
  logic rxrdy_n, txrdy_n;

  always #10 clk = ~clk;

  uart_dma_ready i_uart_dma_ready (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
    .trig_sel(trig_sel), .mode(mode), .rx_push(rx_push), .rx_pop(rx_pop),
    .char_tick(char_tick), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int lvl[NCH], txl[NCH], cnt[NCH], tsel[NCH];
  bit hold[NCH], md[NCH], pu[NCH], po[NCH], tk[NCH];

  function automatic int trig_of(int s);
    case (s) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic idle_all();
    for (int c = 0; c < NCH; c++) begin
      lvl[c] = 0; txl[c] = 5; md[c] = 0; tsel[c] = 3;
      pu[c] = 0; po[c] = 0; tk[c] = 0;
    end
  endtask

  // Apply one cycle of stimulus, advance the model, compare at the next negedge
  task automatic step(string tag);
    logic [NCH-1:0] rxa, txa;
    bit a1;
    for (int c = 0; c < NCH; c++) begin
      rx_level[c*LW +: LW] = LW'(lvl[c]);
      tx_level[c*LW +: LW] = LW'(txl[c]);
      trig_sel[c*2 +: 2]   = 2'(tsel[c]);
      mode[c] = md[c]; rx_push[c] = pu[c]; rx_pop[c] = po[c]; char_tick[c] = tk[c];
      a1 = (lvl[c] != 0) && (hold[c] || lvl[c] >= trig_of(tsel[c]) || cnt[c] == 4);
      rxa[c] = md[c] ? a1 : (lvl[c] != 0);
      txa[c] = md[c] ? (txl[c] < 16) : (txl[c] == 0);
    end
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin
      hold[c] = (lvl[c] != 0) && (hold[c] || lvl[c] >= trig_of(tsel[c]) || cnt[c] == 4);
      if (pu[c] || po[c] || lvl[c] == 0) cnt[c] = 0;
      else if (tk[c] && cnt[c] != 4)   cnt[c] = cnt[c] + 1;
    end
    @(negedge clk);
    chk({tag, " rx"}, rxrdy_n, ~|rxa);
    chk({tag, " tx"}, txrdy_n, ~|txa);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_all();
    for (int c = 0; c < NCH; c++) begin cnt[c] = 0; hold[c] = 0; txl[c] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 reset rx", rxrdy_n, 1'b1);
    chk("R1 reset tx", txrdy_n, 1'b0);
    rst_n = 1'b1;
    step("R1 post-reset");
    chk("R1 idle tx low", txrdy_n, 1'b0);
    idle_all();
    step("R1 settle");

    // R2 mode 0 occupancy
    lvl[2] = 1; step("R2 nonempty");
    chk("R2 asserted", rxrdy_n, 1'b0);
    lvl[2] = 0; step("R2 empty");
    chk("R2 released", rxrdy_n, 1'b1);

    // R3 trigger sweep on channel 0
    md[0] = 1;
    for (int s = 0; s < 4; s++) begin
      tsel[0] = s;
      lvl[0] = trig_of(s) - 1; step("R3 below");
      chk("R3 below trigger", rxrdy_n, (s == 0) ? 1'b1 : 1'b1);
      lvl[0] = trig_of(s); step("R3 at");
      chk("R3 at trigger", rxrdy_n, 1'b0);
      lvl[0] = 0; step("R3 drain");
    end

    // R4 sticky release
    tsel[0] = 2; lvl[0] = 8; step("R4 trig");
    lvl[0] = 3; step("R4 below"); chk("R4 still low", rxrdy_n, 1'b0);
    lvl[0] = 1; step("R4 one");   chk("R4 still low at 1", rxrdy_n, 1'b0);
    lvl[0] = 0; step("R4 empty"); chk("R4 released", rxrdy_n, 1'b1);
    md[0] = 0;

    // R5 timeout
    md[1] = 1; tsel[1] = 3; lvl[1] = 2;
    tk[1] = 1;
    for (int i = 0; i < 4; i++) begin
      step("R5 tick"); chk("R5 not yet", rxrdy_n, 1'b1);
    end
    tk[1] = 0; step("R5 expire"); chk("R5 timeout asserts", rxrdy_n, 1'b0);
    lvl[1] = 0; step("R5 drain"); chk("R5 drain releases", rxrdy_n, 1'b1);

    // R6 restart wins over a same-cycle tick
    lvl[1] = 2; tk[1] = 1;
    for (int i = 0; i < 3; i++) step("R6 pre");
    pu[1] = 1; step("R6 push+tick"); pu[1] = 0; lvl[1] = 3;
    for (int i = 0; i < 3; i++) step("R6 post");
    tk[1] = 0; step("R6 hold"); chk("R6 restarted count", rxrdy_n, 1'b1);
    tk[1] = 1; step("R6 fourth"); tk[1] = 0; step("R6 fire");
    chk("R6 fires after full count", rxrdy_n, 1'b0);
    lvl[1] = 0; step("R6 drain");

    // R7 no counting while empty
    tsel[1] = 1; tk[1] = 1;
    for (int i = 0; i < 6; i++) step("R7 empty ticks");
    tk[1] = 0; lvl[1] = 1; step("R7 first byte"); step("R7 wait");
    chk("R7 no stale timeout", rxrdy_n, 1'b1);
    idle_all(); step("R7 clear");

    // R8 / R9 transmit
    txl[3] = 0; step("R8 empty"); chk("R8 empty asserts", txrdy_n, 1'b0);
    txl[3] = 1; step("R8 one byte"); chk("R8 one byte releases", txrdy_n, 1'b1);
    md[3] = 1; txl[3] = 15; step("R9 room"); chk("R9 room asserts", txrdy_n, 1'b0);
    txl[3] = 16; step("R9 full"); chk("R9 full releases", txrdy_n, 1'b1);

    // R10 combine: one channel requesting among idle ones
    idle_all(); lvl[3] = 4; txl[2] = 0; step("R10 one of four");
    chk("R10 rx any", rxrdy_n, 1'b0); chk("R10 tx any", txrdy_n, 1'b0);

    // R11 registered: input change has no effect before the edge
    lvl[3] = 0; txl[2] = 5;
    rx_level = '0; tx_level = {4{5'd5}};
    #5; chk("R11 rx held", rxrdy_n, 1'b0); chk("R11 tx held", txrdy_n, 1'b0);
    step("R11 after edge");

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      if (n % 200 == 0)
        for (int c = 0; c < NCH; c++) begin md[c] = $urandom_range(1); tsel[c] = $urandom_range(3); end
      for (int c = 0; c < NCH; c++) begin
        pu[c] = ($urandom_range(3) == 0) && lvl[c] < 16;
        po[c] = ($urandom_range(4) == 0) && lvl[c] > 0;
        tk[c] = ($urandom_range(2) == 0);
        case ($urandom_range(5))
          0: txl[c] = 0;
          1: txl[c] = 16;
          default: if ($urandom_range(7) == 0) txl[c] = $urandom_range(16);
        endcase
      end
      step("R2-R10 random");
      for (int c = 0; c < NCH; c++) lvl[c] = lvl[c] + int'(pu[c]) - int'(po[c]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule